// File: doc/BRIEF.md
# UTMI Dual-Width Data Bus Adapter

This block sits between a byte-oriented packet engine and the data port of a UTMI-style high-speed transceiver. On the transmit side it takes words of up to two bytes from a FIFO-like source. It raises the transmit-valid line for the length of one packet and presents one item per cycle toward the transceiver. It moves to the next item only on a clock edge where the transceiver signals ready. On the receive side it registers each word that the transceiver marks valid, and it reports how many bytes the word carries. It also passes the receive-active and receive-error indications through, with the same alignment as the data, and it produces an end-of-packet pulse that carries a packet-level error flag.

A static width input selects one of two bus arrangements. In wide mode both byte lanes form one shared bus, and a high-byte-valid strobe travels with the data. While transmitting, the adapter drives the bus and the strobe. Otherwise the bus and the strobe are inputs from the transceiver. In narrow mode the lower lane carries transmit bytes and the upper lane carries receive bytes. A word with two bytes is then sent as two consecutive bytes. Because the ports are plain signals, the bus is exposed as an output value, an input value and one output enable per byte lane, and the strobe is exposed the same way. The chip's pad logic combines them.

Line signalling, SYNC/EOP generation and bit stuffing remain inside the transceiver. The width input may change only while no packet is moving in either direction.

Top module: `utmi_width_adapter`

## Requirements
- R1: During and directly after reset, phy_txvalid, tx_pop, bus_oe, hv_oe, rx_strobe, rx_cnt, rx_err, rx_active, rx_eop and rx_eop_bad are all zero.
- R2: When tx_avail is high while idle, with phy_rxactive and phy_rxvalid both low, phy_txvalid rises on the next edge and the first word is presented. A transmit never starts while phy_rxactive or phy_rxvalid is high.
- R3: While phy_txvalid is high and phy_txready is low, bus_out and hv_out hold their values on the next cycle, and phy_txvalid stays high.
- R4: In wide mode (cfg_wide=1) a transmit word is driven whole on bus_out, with bus_oe=2'b11, hv_oe=1, and hv_out equal to the word's tx_two (1 = both bytes valid, 0 = only bus_out[7:0] valid).
- R5: In narrow mode (cfg_wide=0) bytes go out on bus_out[7:0], with bus_out[15:8]=0, bus_oe=2'b01 and hv_oe=0. A word with tx_two=1 is sent as its low byte and then its high byte. A word with tx_two=0 is sent as its low byte only.
- R6: phy_txvalid falls on the edge that accepts the final item of a word marked tx_last. It also falls on the edge that accepts the final item of a word when tx_avail is low at that edge.
- R7: bus_oe and hv_oe are zero in every cycle where phy_txvalid is low.
- R8: In wide mode, a cycle with phy_rxvalid=1 while no transmit is active gives rx_strobe=1 on the next cycle. With hv_in=1, rx_data equals bus_in and rx_cnt=2. With hv_in=0, rx_data equals bus_in[7:0] zero-extended and rx_cnt=1.
- R9: In narrow mode, a received byte is taken from bus_in[15:8] and delivered in rx_data[7:0], with rx_data[15:8]=0 and rx_cnt=1. hv_in and bus_in[7:0] have no effect.
- R10: A cycle with phy_rxvalid=0 produces no rx_strobe, and rx_cnt is 0 whenever rx_strobe is 0, whatever bus_in carries.
- R11: rx_err and rx_active are phy_rxerror and phy_rxactive delayed by one cycle, so an error reaches the output in the same cycle as the word received with it.
- R12: One cycle after phy_rxactive falls, rx_eop pulses for one cycle. rx_eop_bad is high with it exactly when phy_rxerror was seen during the packet, including the falling cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 = shared 16-bit bus, 0 = split 8-bit lanes |
| tx_word | input | 16 | Transmit word from the source, low byte first |
| tx_two | input | 1 | Word carries two valid bytes |
| tx_last | input | 1 | Word ends the packet |
| tx_avail | input | 1 | Source has a word ready |
| tx_pop | output | 1 | Source word taken at this edge |
| phy_txvalid | output | 1 | Transmit valid toward transceiver |
| phy_txready | input | 1 | Transceiver accepted current item |
| phy_rxvalid | input | 1 | Received word valid this cycle |
| phy_rxactive | input | 1 | Receive packet in progress |
| phy_rxerror | input | 1 | Receive error, aligned with data |
| bus_out | output | 16 | Data value driven to the bus |
| bus_in | input | 16 | Data value read from the bus |
| bus_oe | output | 2 | Drive enable per byte lane |
| hv_out | output | 1 | High-byte-valid value when driving |
| hv_in | input | 1 | High-byte-valid value from transceiver |
| hv_oe | output | 1 | Drive enable of the high-byte-valid strobe |
| rx_data | output | 16 | Captured receive word |
| rx_cnt | output | 2 | Bytes in rx_data (0, 1 or 2) |
| rx_strobe | output | 1 | rx_data holds a new word |
| rx_err | output | 1 | Receive error, aligned with rx_strobe |
| rx_active | output | 1 | Registered receive-active |
| rx_eop | output | 1 | One-cycle end-of-packet pulse |
| rx_eop_bad | output | 1 | Packet that just ended saw an error |

## Verification
On every cycle the assertions check several cycle-level rules. A stalled item holds on the bus. No lane is enabled outside a transmit. A transmit never starts inside a receive packet. Every strobe follows a valid receive cycle with a legal byte count, and the end pulse follows a fall of receive-active. The scenarios cover the rest, because that needs expected content. This includes byte order in narrow mode and the high-byte flag on an odd final word. It also includes where the packet ends after the last word or after the source runs dry, the zero-extension of single received bytes, and whether an error mid-packet is reported at the end of that packet.

// File: rtl/utmi_wa_pkg.sv
package utmi_wa_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [WORD_W-1:0]  word;
        logic               two;
        logic               last;
        logic               phase;
    } tx_regs_t;

    typedef struct packed {
        logic [WORD_W-1:0]  data;
        logic [CNT_W-1:0]   cnt;
        logic               strobe;
        logic               err;
        logic               active;
        logic               eop;
        logic               bad;
        logic               seen;
    } rx_regs_t;
endpackage

// File: rtl/utmi_wa_tx.sv
module utmi_wa_tx
    import utmi_wa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic [WORD_W-1:0] src_word,
    input  logic              src_two,
    input  logic              src_last,
    input  logic              src_avail,
    input  logic              xcvr_ready,
    input  logic              xcvr_rxactive,
    input  logic              xcvr_rxvalid,
    output logic              src_pop,
    output logic              sending,
    output logic [WORD_W-1:0] cur_word,
    output logic              cur_two,
    output logic              cur_phase
);
    tx_regs_t tx_d, tx_q;

    always_comb begin
        tx_d    = tx_q;
        src_pop = 1'b0;
        unique case (tx_q.st)
            TX_IDLE: begin
                if (src_avail && !xcvr_rxactive && !xcvr_rxvalid) begin
                    tx_d.st    = TX_SEND;
                    tx_d.word  = src_word;
                    tx_d.two   = src_two;
                    tx_d.last  = src_last;
                    tx_d.phase = 1'b0;
                    src_pop    = 1'b1;
                end
            end
            TX_SEND: begin
                if (xcvr_ready) begin
                    if (!wide && tx_q.two && !tx_q.phase) begin
                        tx_d.phase = 1'b1;
                    end else if (tx_q.last || !src_avail) begin
                        tx_d.st    = TX_IDLE;
                        tx_d.phase = 1'b0;
                    end else begin
                        tx_d.word  = src_word;
                        tx_d.two   = src_two;
                        tx_d.last  = src_last;
                        tx_d.phase = 1'b0;
                        src_pop    = 1'b1;
                    end
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sending   = (tx_q.st == TX_SEND);
    assign cur_word  = tx_q.word;
    assign cur_two   = tx_q.two;
    assign cur_phase = tx_q.phase;
endmodule

// File: rtl/utmi_wa_lanes.sv
module utmi_wa_lanes
    import utmi_wa_pkg::*;
(
    input  logic              wide,
    input  logic              sending,
    input  logic [WORD_W-1:0] cur_word,
    input  logic              cur_two,
    input  logic              cur_phase,
    output logic [WORD_W-1:0] lane_out,
    output logic [LANES-1:0]  lane_oe,
    output logic              hv_val,
    output logic              hv_en
);
    logic [BYTE_W-1:0] narrow_byte;

    assign narrow_byte = cur_phase ? cur_word[BYTE_W +: BYTE_W] : cur_word[0 +: BYTE_W];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_low
            assign lane_out[0 +: BYTE_W] = wide ? cur_word[0 +: BYTE_W] : narrow_byte;
            assign lane_oe[0]            = sending;
        end else begin : g_up
            assign lane_out[i*BYTE_W +: BYTE_W] = wide ? cur_word[i*BYTE_W +: BYTE_W] : '0;
            assign lane_oe[i]                   = sending && wide;
        end
    end

    assign hv_en  = sending && wide;
    assign hv_val = sending && wide && cur_two;
endmodule

// File: rtl/utmi_wa_rx.sv
module utmi_wa_rx
    import utmi_wa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              tx_busy,
    input  logic              xcvr_rxvalid,
    input  logic              xcvr_rxactive,
    input  logic              xcvr_rxerror,
    input  logic [WORD_W-1:0] lane_in,
    input  logic              hv_val,
    output logic [WORD_W-1:0] cap_data,
    output logic [CNT_W-1:0]  cap_cnt,
    output logic              cap_strobe,
    output logic              cap_err,
    output logic              cap_active,
    output logic              pkt_end,
    output logic              pkt_bad
);
    rx_regs_t rx_d, rx_q;

    always_comb begin
        rx_d        = rx_q;
        rx_d.strobe = 1'b0;
        rx_d.cnt    = '0;
        rx_d.eop    = 1'b0;
        rx_d.bad    = 1'b0;
        rx_d.err    = xcvr_rxerror;
        rx_d.active = xcvr_rxactive;

        if (xcvr_rxvalid && !tx_busy) begin
            rx_d.strobe = 1'b1;
            if (wide) begin
                if (hv_val) begin
                    rx_d.data = lane_in;
                    rx_d.cnt  = CNT_W'(LANES);
                end else begin
                    rx_d.data = {{(WORD_W-BYTE_W){1'b0}}, lane_in[BYTE_W-1:0]};
                    rx_d.cnt  = CNT_W'(1);
                end
            end else begin
                rx_d.data = {{(WORD_W-BYTE_W){1'b0}}, lane_in[WORD_W-1 -: BYTE_W]};
                rx_d.cnt  = CNT_W'(1);
            end
        end

        if (rx_q.active && !xcvr_rxactive) begin
            rx_d.eop  = 1'b1;
            rx_d.bad  = rx_q.seen || xcvr_rxerror;
            rx_d.seen = 1'b0;
        end else if (xcvr_rxactive && xcvr_rxerror) begin
            rx_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign cap_data   = rx_q.data;
    assign cap_cnt    = rx_q.cnt;
    assign cap_strobe = rx_q.strobe;
    assign cap_err    = rx_q.err;
    assign cap_active = rx_q.active;
    assign pkt_end    = rx_q.eop;
    assign pkt_bad    = rx_q.bad;
endmodule

// File: rtl/utmi_width_adapter.sv
module utmi_width_adapter
    import utmi_wa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_two,
    input  logic              tx_last,
    input  logic              tx_avail,
    output logic              tx_pop,
    output logic              phy_txvalid,
    input  logic              phy_txready,
    input  logic              phy_rxvalid,
    input  logic              phy_rxactive,
    input  logic              phy_rxerror,
    output logic [WORD_W-1:0] bus_out,
    input  logic [WORD_W-1:0] bus_in,
    output logic [LANES-1:0]  bus_oe,
    output logic              hv_out,
    input  logic              hv_in,
    output logic              hv_oe,
    output logic [WORD_W-1:0] rx_data,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic              rx_strobe,
    output logic              rx_err,
    output logic              rx_active,
    output logic              rx_eop,
    output logic              rx_eop_bad
);
    logic              sending;
    logic [WORD_W-1:0] cur_word;
    logic              cur_two;
    logic              cur_phase;

    utmi_wa_tx u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide          (cfg_wide),
        .src_word      (tx_word),
        .src_two       (tx_two),
        .src_last      (tx_last),
        .src_avail     (tx_avail),
        .xcvr_ready    (phy_txready),
        .xcvr_rxactive (phy_rxactive),
        .xcvr_rxvalid  (phy_rxvalid),
        .src_pop       (tx_pop),
        .sending       (sending),
        .cur_word      (cur_word),
        .cur_two       (cur_two),
        .cur_phase     (cur_phase)
    );

    utmi_wa_lanes u_lanes (
        .wide      (cfg_wide),
        .sending   (sending),
        .cur_word  (cur_word),
        .cur_two   (cur_two),
        .cur_phase (cur_phase),
        .lane_out  (bus_out),
        .lane_oe   (bus_oe),
        .hv_val    (hv_out),
        .hv_en     (hv_oe)
    );

    utmi_wa_rx u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide          (cfg_wide),
        .tx_busy       (sending),
        .xcvr_rxvalid  (phy_rxvalid),
        .xcvr_rxactive (phy_rxactive),
        .xcvr_rxerror  (phy_rxerror),
        .lane_in       (bus_in),
        .hv_val        (hv_in),
        .cap_data      (rx_data),
        .cap_cnt       (rx_cnt),
        .cap_strobe    (rx_strobe),
        .cap_err       (rx_err),
        .cap_active    (rx_active),
        .pkt_end       (rx_eop),
        .pkt_bad       (rx_eop_bad)
    );

    assign phy_txvalid = sending;
endmodule

// File: rtl/utmi_wa_checker.sv
module utmi_wa_checker
    import utmi_wa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              phy_txvalid,
    input logic              phy_txready,
    input logic              phy_rxvalid,
    input logic              phy_rxactive,
    input logic [WORD_W-1:0] bus_out,
    input logic [LANES-1:0]  bus_oe,
    input logic              hv_out,
    input logic              hv_oe,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              rx_strobe,
    input logic              rx_active,
    input logic              rx_eop
);
    // R2: a packet only begins outside receive activity
    a_r2_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_txvalid) |-> $past(!phy_rxactive && !phy_rxvalid));

    // R3: a stalled item stays put
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_txvalid && !phy_txready) |=> (phy_txvalid && $stable(bus_out) && $stable(hv_out)));

    // R7: no lane driven outside a transmit
    a_r7_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_txvalid |-> (bus_oe == '0) && !hv_oe);

    // R8: a strobe follows an accepted receive cycle
    a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(phy_rxvalid && !phy_txvalid));

    // R8: legal byte count with a strobe
    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> (rx_cnt == CNT_W'(1)) || (rx_cnt == CNT_W'(LANES)));

    // R10: no count without a strobe
    a_r10_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |-> rx_cnt == '0);

    // R12: end pulse follows the fall of receive activity
    a_r12_eop_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |-> (!rx_active && $past(rx_active)));
endmodule

bind utmi_width_adapter utmi_wa_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_txvalid  (phy_txvalid),
    .phy_txready  (phy_txready),
    .phy_rxvalid  (phy_rxvalid),
    .phy_rxactive (phy_rxactive),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .hv_out       (hv_out),
    .hv_oe        (hv_oe),
    .rx_cnt       (rx_cnt),
    .rx_strobe    (rx_strobe),
    .rx_active    (rx_active),
    .rx_eop       (rx_eop)
);

// File: tb/utmi_width_adapter_tb.sv
module utmi_width_adapter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cfg_wide;
    logic [15:0] tx_word;
    logic        tx_two, tx_last, tx_avail, tx_pop;
    logic        phy_txvalid, phy_txready, phy_rxvalid, phy_rxactive, phy_rxerror;
    logic [15:0] bus_out, bus_in;
    logic [1:0]  bus_oe;
    logic        hv_out, hv_in, hv_oe;
    logic [15:0] rx_data;
    logic [1:0]  rx_cnt;
    logic        rx_strobe, rx_err, rx_active, rx_eop, rx_eop_bad;

    int vectors = 0;
    int errors  = 0;

    typedef struct packed { logic wide; logic [15:0] data; logic hv; logic last; } tx_item_t;
    typedef struct packed { logic [15:0] data; logic [1:0] cnt; logic err; } rx_item_t;
    tx_item_t txq[$];
    rx_item_t rxq[$];
    logic     eopq[$];

    logic [15:0] s_w[64];
    logic        s_two[64];
    logic        s_last[64];
    int          s_n = 0;
    int          s_rd = 0;

    assign tx_avail = (s_rd != s_n);
    assign tx_word  = s_w[s_rd];
    assign tx_two   = s_two[s_rd];
    assign tx_last  = s_last[s_rd];

    always @(posedge clk) begin
        if (!rst_n) s_rd <= 0;
        else if (tx_pop) s_rd <= s_rd + 1;
    end

    logic [1:0] rc = 2'd0;
    always @(posedge clk) rc <= rc + 2'd1;
    assign phy_txready = (rc != 2'd1);

    utmi_width_adapter u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic add_word(input logic [15:0] w, input logic two, input logic last, input logic final_w);
        s_w[s_n]    = w;
        s_two[s_n]  = two;
        s_last[s_n] = last;
        s_n++;
        if (cfg_wide) begin
            txq.push_back('{1'b1, w, two, last | final_w});
        end else if (two) begin
            txq.push_back('{1'b0, {8'h00, w[7:0]}, 1'b0, 1'b0});
            txq.push_back('{1'b0, {8'h00, w[15:8]}, 1'b0, last | final_w});
        end else begin
            txq.push_back('{1'b0, {8'h00, w[7:0]}, 1'b0, last | final_w});
        end
    endtask

    logic pkt_err = 1'b0;
    task automatic rx_cycle(input logic act, input logic vld, input logic [15:0] d,
                            input logic hv, input logic err);
        @(negedge clk);
        if (phy_rxactive && !act) begin
            eopq.push_back(pkt_err | err);
            pkt_err = 1'b0;
        end else if (act && err) begin
            pkt_err = 1'b1;
        end
        phy_rxactive = act;
        phy_rxvalid  = vld;
        bus_in       = d;
        hv_in        = hv;
        phy_rxerror  = err;
        if (vld) begin
            if (cfg_wide)
                rxq.push_back('{hv ? d : {8'h00, d[7:0]}, hv ? 2'd2 : 2'd1, err});
            else
                rxq.push_back('{{8'h00, d[15:8]}, 2'd1, err});
        end
    endtask

    task automatic wait_tx();
        for (int i = 0; i < 300 && (txq.size() != 0 || phy_txvalid || tx_avail); i++)
            @(negedge clk);
        @(negedge clk);
        check("R6 all items sent", txq.size(), 0);
    endtask

    // scoreboard monitor
    logic        hold_chk = 1'b0;
    logic [16:0] hold_val = '0;
    logic        end_pend = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (end_pend) begin
                check("R6 txvalid low after final item", phy_txvalid, 0);
                end_pend = 1'b0;
            end
            if (phy_txvalid) begin
                if (hold_chk) check("R3 stalled item held", {hv_out, bus_out}, hold_val);
                hold_chk = 1'b0;
                if (phy_txready) begin
                    if (txq.size() == 0) begin
                        check("R2 unexpected transmit item", 1, 0);
                    end else begin
                        tx_item_t e;
                        e = txq.pop_front();
                        if (e.wide) begin
                            check("R4 wide word", bus_out, e.data);
                            check("R4 high-valid", hv_out, e.hv);
                            check("R4 enables", {hv_oe, bus_oe}, 3'b111);
                        end else begin
                            check("R5 narrow byte", bus_out, e.data);
                            check("R5 enables", {hv_oe, bus_oe}, 3'b001);
                        end
                        end_pend = e.last;
                    end
                end else begin
                    hold_chk = 1'b1;
                    hold_val = {hv_out, bus_out};
                end
            end else begin
                hold_chk = 1'b0;
                check("R7 undriven when idle", {hv_oe, bus_oe}, 3'b000);
            end

            if (rx_strobe) begin
                if (rxq.size() == 0) begin
                    check("R10 unexpected strobe", 1, 0);
                end else begin
                    rx_item_t r;
                    r = rxq.pop_front();
                    check(cfg_wide ? "R8 rx data" : "R9 rx data", rx_data, r.data);
                    check(cfg_wide ? "R8 rx count" : "R9 rx count", rx_cnt, r.cnt);
                    check("R11 rx error aligned", rx_err, r.err);
                    check("R11 rx active", rx_active, 1);
                end
            end else begin
                check("R10 count zero without strobe", rx_cnt, 0);
            end

            if (rx_eop) begin
                if (eopq.size() == 0) check("R12 unexpected eop", 1, 0);
                else check("R12 eop error flag", rx_eop_bad, eopq.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            s_w[i] = '0; s_two[i] = 1'b0; s_last[i] = 1'b0;
        end
        cfg_wide = 1'b1;
        phy_rxvalid = 1'b0; phy_rxactive = 1'b0; phy_rxerror = 1'b0;
        bus_in = '0; hv_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 txvalid in reset", phy_txvalid, 0);
        check("R1 pop in reset", tx_pop, 0);
        check("R1 enables in reset", {hv_oe, bus_oe}, 0);
        check("R1 rx flags in reset", {rx_strobe, rx_cnt, rx_err, rx_active, rx_eop, rx_eop_bad}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {phy_txvalid, rx_strobe, rx_eop}, 0);

        // R4: wide packet, odd last word
        add_word(16'h1234, 1'b1, 1'b0, 1'b0);
        add_word(16'hABCD, 1'b1, 1'b0, 1'b0);
        add_word(16'h00EF, 1'b0, 1'b1, 1'b1);
        wait_tx();

        // R5: narrow packet, two bytes then one
        cfg_wide = 1'b0;
        add_word(16'hA1B2, 1'b1, 1'b0, 1'b0);
        add_word(16'h00C3, 1'b0, 1'b1, 1'b1);
        wait_tx();

        // R6: source runs dry after a non-last word
        add_word(16'h5566, 1'b1, 1'b0, 1'b1);
        wait_tx();

        // R8, R10, R11, R12: wide receive with gaps and an error
        cfg_wide = 1'b1;
        rx_cycle(1, 0, 16'hFFFF, 1, 0);
        rx_cycle(1, 1, 16'hBEEF, 1, 0);
        rx_cycle(1, 0, 16'h1111, 1, 0);
        rx_cycle(1, 1, 16'h7788, 0, 1);
        rx_cycle(1, 1, 16'hC0DE, 1, 0);
        rx_cycle(0, 0, 16'h2222, 1, 0);
        rx_cycle(0, 0, 16'h0000, 0, 0);
        rx_cycle(0, 0, 16'h0000, 0, 0);

        // R9, R12: narrow receive, clean packet
        cfg_wide = 1'b0;
        rx_cycle(1, 1, 16'h5AA5, 0, 0);
        rx_cycle(1, 1, 16'h3C99, 1, 0);
        rx_cycle(0, 0, 16'hFFFF, 0, 0);
        rx_cycle(0, 0, 16'h0000, 0, 0);
        rx_cycle(0, 0, 16'h0000, 0, 0);

        // R2: transmit held off while receive active
        cfg_wide = 1'b1;
        rx_cycle(1, 0, 16'h0000, 0, 0);
        add_word(16'h0F0F, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2 no start during receive", phy_txvalid, 0);
        end
        rx_cycle(0, 0, 16'h0000, 0, 0);
        @(negedge clk);
        check("R2 start after receive ends", phy_txvalid, 1);
        wait_tx();

        repeat (4) @(negedge clk);
        check("R8 rx queue drained", rxq.size(), 0);
        check("R12 eop queue drained", eopq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule